// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block owns the DDR SDRAM command bus from the moment reset is released until the memory is ready for ordinary traffic. It holds clock enable low through a long start-up delay, then raises it and walks the device through a fixed series of commands, keeping a timed quiet gap after each one. The series is: a precharge of every bank, a mode-register load that also resets the DLL, a second all-bank precharge, two auto-refresh cycles, and a final mode-register load that leaves the DLL running. Every gap is a parameter counted in controller clock cycles.

When the last gap has elapsed, the block pulses `init_done` for one cycle. From then on it keeps clock enable high and drives NOP, so the normal command logic can take over the bus. The mode word comes from three parameters: burst length, burst ordering and CAS latency. A synchronous reset at any point restarts the whole series from the beginning.

Top module: `ddr_powerup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the registered outputs after that edge are `mem_cke`=0, `mem_cs_n`=1 and `init_done`=0.
- R2: Counting the first edge with `rst` low as cycle 1, cycles 1 to T_START show `mem_cke`=0 with the bus deselected (`mem_cs_n`=1).
- R3: For the next T_CKE_NOP cycles, `mem_cke`=1 and the bus carries NOP ({cs_n,ras_n,cas_n,we_n}=0111). The first precharge-all follows in cycle T_START+T_CKE_NOP+1, encoded 0010 with address bit 10 high and every other address bit low.
- R4: The first mode load (encoded 0000) comes exactly T_RP cycles after the first precharge, with bank address 0 and address bit 8 (DLL reset) high.
- R5: The second precharge-all comes exactly T_MRD cycles after the first mode load.
- R6: The first auto-refresh (encoded 0001, address 0) comes T_RP cycles after the second precharge. The second auto-refresh comes T_RFC cycles after the first, and the final mode load comes T_RFC cycles after the second.
- R7: The mode word sits in address bits 12..0. Bits 2..0 carry the burst length (2→001, 4→010, 8→011). Bit 3 is the ordering (1 = interleaved). Bits 6..4 carry the CAS latency (2→010, 2.5→110, 3→011). Bits 12..7 are the operating mode, which is all zero in the final load. Bank address is 0 in both loads.
- R8: Once clock enable rises, it stays high until the next reset. Every cycle that carries no command from R3 to R6 carries NOP, never a deselect.
- R9: `init_done` is high for exactly one cycle, T_MRD cycles after the final mode load, with NOP on the bus in that cycle. After it, no further command appears.
- R10: A reset arriving in the cycle where a command or the `init_done` pulse is due wins: the outputs go quiet as in R1, and the full series restarts on release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_cke | output | 1 | Memory clock enable |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ba | output | BA_W | Bank address |
| mem_addr | output | ADDR_W | Address / mode word |
| init_done | output | 1 | One-cycle pulse when the series is complete |

## Verification
Two things can land on the same edge: a synchronous reset, and an issue slot where the sequencer would otherwise emit a command or its completion pulse. The bench asserts reset for exactly that edge at three points: the first mode load, the first NOP cycle after clock enable rises, and the `init_done` cycle. In each case it requires quiet outputs on that edge and no leftover pulse. A full, uninterrupted series must then follow, with every gap measured against the parameters.

// File: rtl/ddr_init_pkg.sv
`timescale 1ns/1ps
package ddr_init_pkg;

    // Steps of the start-up series, in issue order
    typedef enum logic [3:0] {
        PH_WAKE,      // CKE low, bus deselected
        PH_CKE_NOP,   // CKE high, NOP
        PH_PRE_A,     // first all-bank precharge
        PH_MRS_DLL,   // mode load with DLL reset
        PH_PRE_B,     // second all-bank precharge
        PH_AREF_A,    // first auto-refresh
        PH_AREF_B,    // second auto-refresh
        PH_MRS_RUN,   // final mode load
        PH_READY,     // completion pulse
        PH_IDLE       // hand-over, NOP forever
    } phase_e;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_NOP   = 4'b0111,
        CMD_PRE   = 4'b0010,
        CMD_AREF  = 4'b0001,
        CMD_MRS   = 4'b0000
    } cmd_e;

    localparam int MODE_W      = 13;
    localparam int PRE_ALL_BIT = 10;

    // Mode word, most significant field first (A12 .. A0)
    typedef struct packed {
        logic [5:0] opmode;
        logic [2:0] cas_lat;
        logic       interleave;
        logic [2:0] burst_len;
    } mode_word_t;

    function automatic logic [2:0] burst_code(input int len);
        case (len)
            2:       return 3'b001;
            8:       return 3'b011;
            default: return 3'b010;
        endcase
    endfunction

    // CAS latency given in half cycles: 4 = 2, 5 = 2.5, 6 = 3
    function automatic logic [2:0] latency_code(input int lat_x2);
        case (lat_x2)
            4:       return 3'b010;
            6:       return 3'b011;
            default: return 3'b110;
        endcase
    endfunction

    function automatic mode_word_t build_mode(input int len, input bit intl,
                                              input int lat_x2, input bit dll_rst);
        mode_word_t m;
        m.burst_len  = burst_code(len);
        m.interleave = intl;
        m.cas_lat    = latency_code(lat_x2);
        m.opmode     = dll_rst ? 6'b000010 : 6'b000000;   // opmode[1] is A8
        return m;
    endfunction

endpackage

// File: rtl/ddr_init_timer.sv
`timescale 1ns/1ps
module ddr_init_timer #(
    parameter int CNT_W   = 8,
    parameter int RST_VAL = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] reload_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= CNT_W'(RST_VAL);
        else if (cnt == '0)
            cnt <= reload_val;
        else
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/ddr_init_fsm.sv
`timescale 1ns/1ps
module ddr_init_fsm
    import ddr_init_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int T_START   = 20000,
    parameter int T_CKE_NOP = 2,
    parameter int T_RP      = 3,
    parameter int T_MRD     = 2,
    parameter int T_RFC     = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             expired,
    output phase_e           phase,
    output logic             fresh,
    output logic [CNT_W-1:0] next_len_m1
);
    function automatic phase_e succ(input phase_e p);
        case (p)
            PH_WAKE:    return PH_CKE_NOP;
            PH_CKE_NOP: return PH_PRE_A;
            PH_PRE_A:   return PH_MRS_DLL;
            PH_MRS_DLL: return PH_PRE_B;
            PH_PRE_B:   return PH_AREF_A;
            PH_AREF_A:  return PH_AREF_B;
            PH_AREF_B:  return PH_MRS_RUN;
            PH_MRS_RUN: return PH_READY;
            default:    return PH_IDLE;
        endcase
    endfunction

    // Phase length minus one, in cycles
    function automatic logic [CNT_W-1:0] len_m1(input phase_e p);
        case (p)
            PH_WAKE:              return CNT_W'(T_START - 1);
            PH_CKE_NOP:           return CNT_W'(T_CKE_NOP - 1);
            PH_PRE_A, PH_PRE_B:   return CNT_W'(T_RP - 1);
            PH_MRS_DLL,
            PH_MRS_RUN:           return CNT_W'(T_MRD - 1);
            PH_AREF_A, PH_AREF_B: return CNT_W'(T_RFC - 1);
            default:              return '0;
        endcase
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_WAKE;
            fresh <= 1'b1;
        end else if (expired) begin
            phase <= succ(phase);
            fresh <= 1'b1;
        end else begin
            fresh <= 1'b0;
        end
    end

    assign next_len_m1 = len_m1(succ(phase));
endmodule

// File: rtl/ddr_cmd_drive.sv
`timescale 1ns/1ps
module ddr_cmd_drive
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W           = 13,
    parameter int BA_W             = 2,
    parameter int BURST_LEN        = 4,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter int CAS_LAT_X2       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              fresh,
    output logic              cke,
    output logic [3:0]        cmd,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done
);
    localparam mode_word_t MODE_DLL = build_mode(BURST_LEN, BURST_INTERLEAVE, CAS_LAT_X2, 1'b1);
    localparam mode_word_t MODE_RUN = build_mode(BURST_LEN, BURST_INTERLEAVE, CAS_LAT_X2, 1'b0);
    localparam logic [ADDR_W-1:0] PRE_ADDR = ADDR_W'(1) << PRE_ALL_BIT;

    logic              cke_d, done_d;
    cmd_e              cmd_d;
    logic [ADDR_W-1:0] addr_d;

    always_comb begin
        cke_d  = 1'b1;
        cmd_d  = CMD_NOP;
        addr_d = '0;
        done_d = 1'b0;
        case (phase)
            PH_WAKE: begin
                cke_d = 1'b0;
                cmd_d = CMD_DESEL;
            end
            PH_PRE_A, PH_PRE_B: if (fresh) begin
                cmd_d  = CMD_PRE;
                addr_d = PRE_ADDR;
            end
            PH_MRS_DLL: if (fresh) begin
                cmd_d  = CMD_MRS;
                addr_d = ADDR_W'(MODE_DLL);
            end
            PH_MRS_RUN: if (fresh) begin
                cmd_d  = CMD_MRS;
                addr_d = ADDR_W'(MODE_RUN);
            end
            PH_AREF_A, PH_AREF_B: if (fresh) cmd_d = CMD_AREF;
            PH_READY: done_d = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cke  <= 1'b0;
            cmd  <= CMD_DESEL;
            addr <= '0;
            done <= 1'b0;
        end else begin
            cke  <= cke_d;
            cmd  <= cmd_d;
            addr <= addr_d;
            done <= done_d;
        end
    end

    // Both mode loads target the base register, so bank address stays zero
    assign ba = '0;
endmodule

// File: rtl/ddr_powerup_seq.sv
`timescale 1ns/1ps
module ddr_powerup_seq
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W           = 13,
    parameter int BA_W             = 2,
    parameter int T_START          = 20000,
    parameter int T_CKE_NOP        = 2,
    parameter int T_RP             = 3,
    parameter int T_MRD            = 2,
    parameter int T_RFC            = 8,
    parameter int BURST_LEN        = 4,
    parameter bit BURST_INTERLEAVE = 1'b0,
    parameter int CAS_LAT_X2       = 5
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_cke,
    output logic              mem_cs_n,
    output logic              mem_ras_n,
    output logic              mem_cas_n,
    output logic              mem_we_n,
    output logic [BA_W-1:0]   mem_ba,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              init_done
);
    localparam int MAX_A   = (T_START > T_CKE_NOP) ? T_START : T_CKE_NOP;
    localparam int MAX_B   = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_C   = (MAX_B > T_RFC) ? MAX_B : T_RFC;
    localparam int MAX_LEN = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    phase_e           phase;
    logic             fresh, expired;
    logic [CNT_W-1:0] next_len_m1;
    logic [3:0]       cmd;

    ddr_init_timer #(.CNT_W(CNT_W), .RST_VAL(T_START - 1)) u_timer (
        .clk(clk), .rst(rst), .reload_val(next_len_m1), .expired(expired)
    );

    ddr_init_fsm #(
        .CNT_W(CNT_W), .T_START(T_START), .T_CKE_NOP(T_CKE_NOP),
        .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC)
    ) u_fsm (
        .clk(clk), .rst(rst), .expired(expired),
        .phase(phase), .fresh(fresh), .next_len_m1(next_len_m1)
    );

    ddr_cmd_drive #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .BURST_LEN(BURST_LEN),
        .BURST_INTERLEAVE(BURST_INTERLEAVE), .CAS_LAT_X2(CAS_LAT_X2)
    ) u_drive (
        .clk(clk), .rst(rst), .phase(phase), .fresh(fresh),
        .cke(mem_cke), .cmd(cmd), .ba(mem_ba), .addr(mem_addr), .done(init_done)
    );

    assign {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n} = cmd;
endmodule

// File: rtl/ddr_powerup_seq_chk.sv
`timescale 1ns/1ps
module ddr_powerup_seq_chk
    import ddr_init_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_cke,
    input logic              mem_cs_n,
    input logic              mem_ras_n,
    input logic              mem_cas_n,
    input logic              mem_we_n,
    input logic [BA_W-1:0]   mem_ba,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              init_done
);
    logic [3:0] bus;
    assign bus = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};

    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!mem_cke && mem_cs_n && !init_done));

    p_desel_while_cke_low_r2: assert property (@(posedge clk) disable iff (rst)
        !mem_cke |-> mem_cs_n);

    p_pre_all_banks_r3: assert property (@(posedge clk) disable iff (rst)
        (bus == CMD_PRE) |-> mem_addr[PRE_ALL_BIT]);

    p_mode_base_bank_r7: assert property (@(posedge clk) disable iff (rst)
        (bus == CMD_MRS) |-> (mem_ba == '0));

    p_cke_stays_high_r8: assert property (@(posedge clk) disable iff (rst)
        mem_cke |=> mem_cke);

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |=> !init_done);

    p_done_on_nop_r9: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (bus == CMD_NOP && mem_cke));
endmodule

bind ddr_powerup_seq ddr_powerup_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
    .clk(clk), .rst(rst), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
    .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
    .mem_ba(mem_ba), .mem_addr(mem_addr), .init_done(init_done)
);

// File: tb/ddr_powerup_seq_tb_top.sv
`timescale 1ns/1ps
module ddr_powerup_seq_tb_top;
    localparam int ADDR_W = 13;
    localparam int BA_W   = 2;
    localparam int TS  = 40;
    localparam int TN  = 2;
    localparam int TRP = 3;
    localparam int TMR = 2;
    localparam int TRF = 7;
    // BL4 -> 010, interleaved -> bit3, CL 2.5 -> 110 in bits 6..4
    localparam logic [12:0] MW_RUN = 13'h06A;
    localparam logic [12:0] MW_DLL = 13'h16A;
    localparam int C_PRE1 = TS + TN + 1;
    localparam int C_LMR1 = C_PRE1 + TRP;
    localparam int C_DONE = C_LMR1 + TMR + TRP + 2 * TRF + TMR;

    typedef struct {
        logic [3:0]  kind;   // bus code, or 4'hD for the completion pulse
        logic [12:0] addr;
        int          gap;
        string       req;
    } ev_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_at_edge = 1'b1;
    logic mem_cke, mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n, init_done;
    logic [BA_W-1:0]   mem_ba;
    logic [ADDR_W-1:0] mem_addr;

    int  n_tests = 0, n_fail = 0;
    int  ncyc = 0, last_ev = 0;
    bit  abort_flag = 1'b0, finished = 1'b0;
    ev_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) rst_at_edge <= rst;

    ddr_powerup_seq #(
        .ADDR_W(ADDR_W), .BA_W(BA_W), .T_START(TS), .T_CKE_NOP(TN), .T_RP(TRP),
        .T_MRD(TMR), .T_RFC(TRF), .BURST_LEN(4), .BURST_INTERLEAVE(1'b1), .CAS_LAT_X2(5)
    ) dut_i (
        .clk(clk), .rst(rst), .mem_cke(mem_cke), .mem_cs_n(mem_cs_n),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_ba(mem_ba), .mem_addr(mem_addr), .init_done(init_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    task automatic push(input logic [3:0] k, input logic [12:0] a, input int g, input string r);
        ev_t e;
        e.kind = k; e.addr = a; e.gap = g; e.req = r;
        exp_q.push_back(e);
    endtask

    // Driver: expected series pushed in issue order
    task automatic plan_series();
        exp_q.delete();
        push(4'b0010, 13'h0400, C_PRE1, "R3");
        push(4'b0000, MW_DLL,   TRP,    "R4");
        push(4'b0010, 13'h0400, TMR,    "R5");
        push(4'b0001, 13'h0000, TRP,    "R6");
        push(4'b0001, 13'h0000, TRF,    "R6");
        push(4'b0000, MW_RUN,   TRF,    "R7");
        push(4'hD,    13'h0000, TMR,    "R9");
    endtask

    task automatic observe(input logic [3:0] k);
        ev_t e;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R9", "unexpected event", {28'h0, k}, 32'h0);
        end else begin
            e = exp_q.pop_front();
            chk(k == e.kind, e.req, "event kind", {28'h0, k}, {28'h0, e.kind});
            if (k != 4'hD) begin
                chk(mem_addr == e.addr, e.req, "address", {19'h0, mem_addr}, {19'h0, e.addr});
                chk(mem_ba == '0, e.req, "bank", {30'h0, mem_ba}, 32'h0);
            end
            chk(ncyc - last_ev == e.gap, e.req, "gap", ncyc - last_ev, e.gap);
        end
        last_ev = ncyc;
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        logic [3:0] bus;
        bus = {mem_cs_n, mem_ras_n, mem_cas_n, mem_we_n};
        if (rst_at_edge) begin
            ncyc = 0; last_ev = 0;
            chk(mem_cke === 1'b0 && mem_cs_n === 1'b1 && init_done === 1'b0,
                abort_flag ? "R10" : "R1", "quiet under reset",
                {29'h0, mem_cke, mem_cs_n, init_done}, 32'h2);
            abort_flag = 1'b0;
        end else begin
            ncyc++;
            if (ncyc <= TS) begin
                chk(mem_cke === 1'b0 && bus === 4'b1111, "R2", "start delay",
                    {27'h0, mem_cke, bus}, 32'h0F);
            end else begin
                chk(mem_cke === 1'b1 && mem_cs_n === 1'b0, "R8", "cke high, selected",
                    {30'h0, mem_cke, mem_cs_n}, 32'h2);
                if (ncyc <= TS + TN)
                    chk(bus === 4'b0111, "R3", "nop after cke", {28'h0, bus}, 32'h7);
                if (bus !== 4'b0111 && mem_cs_n === 1'b0) observe(bus);
            end
            if (init_done === 1'b1) begin
                chk(bus === 4'b0111, "R9", "nop with done", {28'h0, bus}, 32'h7);
                observe(4'hD);
            end
        end
    end

    task automatic hold_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        plan_series();
        #1 rst = 1'b0;
    endtask

    task automatic full_run();
        hold_reset();
        repeat (C_DONE + 40) @(posedge clk);
        #1;
        chk(exp_q.size() == 0, "R9", "series complete", exp_q.size(), 0);
    endtask

    // Reset lands on edge L, where something would otherwise be issued
    task automatic abort_at(input int l);
        hold_reset();
        repeat (l - 1) @(posedge clk);
        #1 rst = 1'b1;
        abort_flag = 1'b1;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    initial begin
        full_run();                 // R1..R9 on a clean series
        abort_at(C_LMR1);           // R10: reset on the first mode load
        full_run();
        abort_at(TS + 1);           // R10: reset just after cke rises
        full_run();
        abort_at(C_DONE);           // R10: reset on the completion pulse
        chk(init_done == 1'b0 && mem_cke == 1'b0, "R10", "no pulse under reset",
            {30'h0, init_done, mem_cke}, 32'h0);
        full_run();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule